// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block links two 8-bit ports, A and B, through two separate storage stages. One stage carries data from A to B and the other carries data from B to A. Each direction has three active-low controls: a chip enable, a latch enable and a drive enable. While the chip enable and the latch enable of a direction are both low, its stage follows the source port. When either control goes high, the stage keeps its last captured word. The destination port is driven only while the chip enable and the drive enable of that direction are both low.

Each port is split into an input bus, an output data bus and a per-bit output-enable vector, so the block contains no inout nets. A surrounding top level combines the data and enable buses into real three-state pins. All storage is sampled on one system clock, and every output comes straight from a flop. A flag reports any cycle in which both directions drive their destination ports together.

Top module: `dual_latch_xcvr`

## Requirements
- R1: A clock edge with `rst` high clears both stored words to zero. The same edge sets `a_oe`, `b_oe` and `both_drive` to zero, whatever the control inputs are.
- R2: If `ab_ce_n` and `ab_le_n` are both sampled low at an edge, `b_out` shows the value that `a_in` had at that edge, from that edge on.
- R3: If `ab_le_n` is sampled high at an edge, the A-to-B word keeps its value, even when `a_in` changes.
- R4: If `ab_ce_n` is sampled high at an edge, the A-to-B word keeps its value, even when `ab_le_n` is low.
- R5: After an edge where `ab_ce_n` and `ab_oe_n` are both sampled low, every bit of `b_oe` is 1. After any other edge, every bit of `b_oe` is 0.
- R6: With `ab_ce_n` low, `ab_le_n` high and `ab_oe_n` low, `b_oe` is all ones and `b_out` keeps showing the word stored earlier.
- R7: The B-to-A direction follows R2 to R6, using `b_in`, `ba_ce_n`, `ba_le_n`, `ba_oe_n`, `a_out` and `a_oe`. Neither direction's controls or data affect the other direction.
- R8: `both_drive` is 1 exactly in the cycles where `a_oe` and `b_oe` are both all ones, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Data arriving on port A |
| b_in | input | 8 | Data arriving on port B |
| ab_ce_n | input | 1 | A-to-B chip enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ba_ce_n | input | 1 | B-to-A chip enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| a_out | output | 8 | Stored B-to-A word presented to port A |
| a_oe | output | 8 | Per-bit drive enable for port A |
| b_out | output | 8 | Stored A-to-B word presented to port B |
| b_oe | output | 8 | Per-bit drive enable for port B |
| both_drive | output | 1 | Both ports driven in the same cycle |

## Verification
The assertions assume that every control and data input is a clean 0 or 1 at each rising edge, and that reset is held high for the first edge. The bench changes its inputs 1 ns after a rising edge and never near the next one, so every sampled value is stable and known. The bench also holds reset for the first cycle of the run, and again for one mid-run cycle, before any property relies on earlier state.

// File: rtl/dlx_pkg.sv
package dlx_pkg;
  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } dlx_ctrl_t;

  localparam int unsigned DLX_NUM_DIR = 2;
endpackage

// File: rtl/dlx_lane.sv
module dlx_lane
  import dlx_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  dlx_ctrl_t        ctrl,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] oe_o,
  output logic             drive_req
);
  logic open_w;

  assign open_w    = !ctrl.ce_n && !ctrl.le_n;
  assign drive_req = !ctrl.ce_n && !ctrl.oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (open_w) begin
      dout <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_o <= '0;
    end else begin
      oe_o <= {WIDTH{drive_req}};
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (dout == '0 && oe_o == '0));

  p_follow_src_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.ce_n && !ctrl.le_n) |=> (dout == $past(din)));

  p_hold_le_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl.le_n |=> $stable(dout));

  p_hold_ce_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl.ce_n |=> $stable(dout));

  p_drive_on_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.ce_n && !ctrl.oe_n) |=> (&oe_o));

  p_drive_off_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.ce_n || ctrl.oe_n) |=> (oe_o == '0));
endmodule

// File: rtl/dlx_clash.sv
module dlx_clash #(
  parameter int unsigned NUM_DIR = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DIR-1:0] req,
  output logic               clash
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clash <= 1'b0;
    end else begin
      clash <= &req;
    end
  end

  p_clash_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (&req) |=> clash);
endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr
  import dlx_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             ab_ce_n,
  input  logic             ab_le_n,
  input  logic             ab_oe_n,
  input  logic             ba_ce_n,
  input  logic             ba_le_n,
  input  logic             ba_oe_n,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe,
  output logic             both_drive
);
  localparam int unsigned NDIR = DLX_NUM_DIR;

  dlx_ctrl_t        lane_ctrl [NDIR];
  logic [WIDTH-1:0] lane_din  [NDIR];
  logic [WIDTH-1:0] lane_dout [NDIR];
  logic [WIDTH-1:0] lane_oe   [NDIR];
  logic [NDIR-1:0]  lane_req;

  // lane 0 carries A to B, lane 1 carries B to A
  assign lane_ctrl[0] = '{ce_n: ab_ce_n, le_n: ab_le_n, oe_n: ab_oe_n};
  assign lane_ctrl[1] = '{ce_n: ba_ce_n, le_n: ba_le_n, oe_n: ba_oe_n};
  assign lane_din[0]  = a_in;
  assign lane_din[1]  = b_in;

  for (genvar g = 0; g < NDIR; g++) begin : g_lane
    dlx_lane #(.WIDTH(WIDTH)) lane_i (
      .clk       (clk),
      .rst       (rst),
      .ctrl      (lane_ctrl[g]),
      .din       (lane_din[g]),
      .dout      (lane_dout[g]),
      .oe_o      (lane_oe[g]),
      .drive_req (lane_req[g])
    );
  end

  assign b_out = lane_dout[0];
  assign b_oe  = lane_oe[0];
  assign a_out = lane_dout[1];
  assign a_oe  = lane_oe[1];

  dlx_clash #(.NUM_DIR(NDIR)) clash_i (
    .clk   (clk),
    .rst   (rst),
    .req   (lane_req),
    .clash (both_drive)
  );

  p_flag_match_r8: assert property (@(posedge clk) disable iff (rst)
    both_drive == ((&a_oe) && (&b_oe)));

  p_dir_isolate_r7: assert property (@(posedge clk) disable iff (rst)
    (ab_ce_n && ab_le_n) |=> $stable(b_out));
endmodule

// File: tb/dual_latch_xcvr_tb.sv
module dual_latch_xcvr_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_ce_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
  logic ba_ce_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic         both_drive;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] exp_ab = '0, exp_ba = '0, exp_aoe = '0, exp_boe = '0;
  logic         exp_flag = 1'b0;

  always #5 clk = ~clk;

  dual_latch_xcvr #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
    .both_drive(both_drive)
  );

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock step against the bench's own model of the requirements
  task automatic cyc(input string tag);
    logic ab_drv, ba_drv;
    ab_drv = !ab_ce_n && !ab_oe_n;
    ba_drv = !ba_ce_n && !ba_oe_n;
    if (rst) begin
      exp_ab = '0; exp_ba = '0; exp_boe = '0; exp_aoe = '0; exp_flag = 1'b0;
    end else begin
      if (!ab_ce_n && !ab_le_n) exp_ab = a_in;
      if (!ba_ce_n && !ba_le_n) exp_ba = b_in;
      exp_boe  = ab_drv ? '1 : '0;
      exp_aoe  = ba_drv ? '1 : '0;
      exp_flag = ab_drv && ba_drv;
    end
    @(posedge clk);
    #1;
    chk(tag, "b_out", b_out, exp_ab);
    chk(tag, "b_oe", b_oe, exp_boe);
    chk(tag, "a_out", a_out, exp_ba);
    chk(tag, "a_oe", a_oe, exp_aoe);
    chk(tag, "both_drive", {7'b0, both_drive}, {7'b0, exp_flag});
  endtask

  task automatic set_ab(input logic ce, input logic le, input logic oe);
    ab_ce_n = ce; ab_le_n = le; ab_oe_n = oe;
  endtask

  task automatic set_ba(input logic ce, input logic le, input logic oe);
    ba_ce_n = ce; ba_le_n = le; ba_oe_n = oe;
  endtask

  task automatic t_reset_r1();
    rst = 1'b1; set_ab(0, 0, 0); set_ba(0, 0, 0);
    a_in = 8'hA5; b_in = 8'h5A;
    cyc("R1");
    rst = 1'b0; set_ab(1, 1, 1); set_ba(1, 1, 1);
    cyc("R1");
  endtask

  task automatic t_follow_r2();
    set_ab(0, 0, 0);
    a_in = 8'h3C; cyc("R2");
    a_in = 8'hFF; cyc("R2");
    a_in = 8'h00; cyc("R2");
    a_in = 8'h81; cyc("R2");
  endtask

  task automatic t_le_close_r3();
    set_ab(0, 0, 1); a_in = 8'h6E; cyc("R3");
    set_ab(0, 1, 1); a_in = 8'h11; cyc("R3");
    a_in = 8'h22; cyc("R3");
  endtask

  task automatic t_ce_close_r4();
    set_ab(0, 0, 1); a_in = 8'h47; cyc("R4");
    set_ab(1, 0, 0); a_in = 8'hB8; cyc("R4");
    a_in = 8'hC9; cyc("R4");
  endtask

  task automatic t_drive_r5();
    for (int k = 0; k < 8; k++) begin
      set_ab(k[2], k[1], k[0]);
      a_in = 8'(k * 29 + 3);
      cyc("R5");
    end
  endtask

  task automatic t_hold_drive_r6();
    set_ab(0, 0, 0); a_in = 8'h9D; cyc("R6");
    set_ab(0, 1, 0); a_in = 8'h04; cyc("R6");
    a_in = 8'hEE; cyc("R6");
  endtask

  task automatic t_reverse_r7();
    set_ab(0, 1, 0);
    set_ba(0, 0, 0); b_in = 8'h72; a_in = 8'h13; cyc("R7");
    b_in = 8'h0F; cyc("R7");
    set_ba(0, 1, 0); b_in = 8'hF0; cyc("R7");
    set_ba(1, 0, 0); b_in = 8'h55; cyc("R7");
    for (int k = 0; k < 8; k++) begin
      set_ba(k[2], k[1], k[0]);
      b_in = 8'(k * 41 + 7);
      cyc("R7");
    end
  endtask

  task automatic t_clash_r8();
    set_ab(0, 1, 0); set_ba(0, 1, 0); cyc("R8");
    set_ab(0, 1, 1); cyc("R8");
    set_ab(0, 0, 0); set_ba(1, 1, 0); a_in = 8'h2B; cyc("R8");
    set_ba(0, 0, 0); b_in = 8'hD4; cyc("R8");
    set_ab(1, 1, 1); set_ba(1, 1, 1); cyc("R8");
  endtask

  task automatic t_reset_mid_r1();
    set_ab(0, 0, 0); set_ba(0, 0, 0); a_in = 8'h99; b_in = 8'h66;
    cyc("R1");
    rst = 1'b1; cyc("R1");
    rst = 1'b0; set_ab(1, 1, 0); set_ba(0, 1, 1); cyc("R1");
  endtask

  initial begin
    #1;
    t_reset_r1();
    t_follow_r2();
    t_le_close_r3();
    t_ce_close_r4();
    t_drive_r5();
    t_hold_drive_r6();
    t_reverse_r7();
    t_clash_r8();
    t_reset_mid_r1();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule